// File: doc/BRIEF.md
# Ternary Polarity Assigner

This block turns a stream of symbol classes into signed three-level line codes for a zero-substitution bipolar line code. The stage before it has already inserted the substitution pulses and marks each symbol as space, mark, balancing pulse or violation. This block assigns a sign to every symbol that is not zero. Marks and balancing pulses take turns between positive and negative as one shared sequence. A violation repeats the sign of the non-zero pulse just before it, so the violations alternate among themselves.

Each output symbol is a 2-bit two's-complement value (+1, -1 or 0). It can drive the select lines of an external analog switch that produces the line levels. The result is registered, so every symbol comes out one clock after it goes in, with a valid flag. Cycles without an input symbol produce no output symbol and leave the polarity state unchanged.

Top module: `ternary_polarity_assigner`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, lineValid is 0 and lineCode is 2'b00.
- R2: lineValid equals symValid delayed by exactly one clock, and lineCode carries the symbol entered in that earlier cycle.
- R3: A space (symClass 2'b00) produces lineCode 2'b00.
- R4: Marks (2'b01) and balancing pulses (2'b10) together form a single alternating sequence. +1 is coded 2'b01 and -1 is coded 2'b11. The first mark or balancing pulse after reset is +1.
- R5: A violation (2'b11) takes the sign of the most recent non-zero output pulse. If no non-zero pulse has occurred since reset, it is -1 (2'b11). It does not change the sign that the next mark or balancing pulse will take.
- R6: For a well-formed substituted stream (an odd number of marks and balancing pulses between violations), consecutive violations have opposite signs.
- R7: A cycle with symValid low gives lineValid 0 and lineCode 2'b00, and does not change the polarity state.
- R8: lineCode never takes the value 2'b10.
- R9: For a well-formed substituted stream, the running sum of the signed output stays within -2..+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | A symbol is present on symClass this cycle |
| symClass | input | 2 | Symbol class: 00 space, 01 mark, 10 balancing pulse, 11 violation |
| lineValid | output | 1 | lineCode holds a symbol |
| lineCode | output | 2 | Signed line level: 01 = +1, 11 = -1, 00 = 0 |

## Verification
A sweep through every three-symbol sequence of (valid, class) pairs, eight choices per cycle, lets the bench tell apart the following: sign changes caused by a mark versus a balancing pulse, violations that must not disturb the shared alternation, and idle cycles that must leave the state alone. Short directed runs cover the corner of a violation before any pulse and the start of alternation after reset. A long random data stream is substituted in the bench into a well-formed class stream. That run separates correct violation sign-copying from plain alternation: the error shows up as a drifting running sum, or as two violations in a row with the same sign.

// File: rtl/tpa_pkg.sv
`timescale 1ns/1ps
package tpa_pkg;
  localparam int CLS_W  = 2;
  localparam int CODE_W = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_SPACE = 2'b00,
    CLS_MARK  = 2'b01,
    CLS_BAL   = 2'b10,
    CLS_VIOL  = 2'b11
  } symClass_e;

  localparam logic [CODE_W-1:0] CODE_ZERO = 2'b00;
  localparam logic [CODE_W-1:0] CODE_POS  = 2'b01;
  localparam logic [CODE_W-1:0] CODE_NEG  = 2'b11;

  // Polarity state after reset: "last pulse negative" so the first
  // alternating pulse comes out positive.
  localparam logic RESET_LAST_NEG = 1'b1;

  typedef struct packed {
    logic load;     // a symbol is accepted this cycle
    logic zero;     // symbol carries no pulse
    logic flip;     // alternating pulse: toggle the shared state
    logic useLast;  // violation: repeat previous sign
  } tpaStrobe_t;
endpackage

// File: rtl/tpa_ctrl.sv
`timescale 1ns/1ps
module tpa_ctrl
  import tpa_pkg::*;
(
  input  logic             symValid,
  input  logic [CLS_W-1:0] symClass,
  output tpaStrobe_t       strobe
);
  always_comb begin
    strobe = '0;
    if (symValid) begin
      strobe.load = 1'b1;
      unique case (symClass)
        CLS_SPACE: strobe.zero    = 1'b1;
        CLS_MARK,
        CLS_BAL:   strobe.flip    = 1'b1;
        CLS_VIOL:  strobe.useLast = 1'b1;
        default:   strobe.zero    = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tpa_datapath.sv
`timescale 1ns/1ps
module tpa_datapath
  import tpa_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tpaStrobe_t        strobe,
  output logic              lineValid,
  output logic [CODE_W-1:0] lineCode
);
  logic              lastNeg;
  logic              pulseNeg;
  logic [CODE_W-1:0] codeNext;

  always_comb begin
    pulseNeg = strobe.useLast ? lastNeg : ~lastNeg;
    if (strobe.load && !strobe.zero)
      codeNext = pulseNeg ? CODE_NEG : CODE_POS;
    else
      codeNext = CODE_ZERO;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastNeg   <= RESET_LAST_NEG;
      lineValid <= 1'b0;
      lineCode  <= CODE_ZERO;
    end else begin
      lineValid <= strobe.load;
      lineCode  <= codeNext;
      if (strobe.flip) lastNeg <= ~lastNeg;
    end
  end
endmodule

// File: rtl/ternary_polarity_assigner.sv
`timescale 1ns/1ps
module ternary_polarity_assigner
  import tpa_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       symValid,
  input  logic [1:0] symClass,
  output logic       lineValid,
  output logic [1:0] lineCode
);
  tpaStrobe_t strobe;

  tpa_ctrl i_ctrl (
    .symValid (symValid),
    .symClass (symClass),
    .strobe   (strobe)
  );

  tpa_datapath i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .lineValid (lineValid),
    .lineCode  (lineCode)
  );
endmodule

// File: rtl/tpa_checker.sv
`timescale 1ns/1ps
module tpa_checker
  import tpa_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       symValid,
  input logic [1:0] symClass,
  input logic       lineValid,
  input logic [1:0] lineCode
);
  // Sign of the most recent non-zero pulse seen at the output.
  logic trkNeg;
  always_ff @(posedge clk) begin
    if (!rstN) trkNeg <= RESET_LAST_NEG;
    else if (lineValid && lineCode != CODE_ZERO) trkNeg <= (lineCode == CODE_NEG);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !lineValid && lineCode == CODE_ZERO);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN) symValid |=> lineValid);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> !lineValid && lineCode == CODE_ZERO);

  // R3
  space_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symClass == CLS_SPACE |=> lineCode == CODE_ZERO);

  // R4
  alt_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    symValid && (symClass == CLS_MARK || symClass == CLS_BAL)
    |=> lineCode == (trkNeg ? CODE_POS : CODE_NEG));

  // R5
  viol_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    symValid && symClass == CLS_VIOL |=> lineCode == (trkNeg ? CODE_NEG : CODE_POS));

  // R8
  no_bad_code_chk: assert property (@(posedge clk) disable iff (!rstN) lineCode != 2'b10);
endmodule

bind ternary_polarity_assigner tpa_checker i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .symValid  (symValid),
  .symClass  (symClass),
  .lineValid (lineValid),
  .lineCode  (lineCode)
);

// File: tb/test_ternary_polarity_assigner.sv
`timescale 1ns/1ps
module test_ternary_polarity_assigner;
  localparam int NBITS = 3000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symClass = 2'b00;
  logic       lineValid;
  logic [1:0] lineCode;

  int checks = 0;
  int failures = 0;
  logic expLastNeg = 1'b1;

  ternary_polarity_assigner i_ternary_polarity_assigner (
    .clk(clk), .rstN(rstN), .symValid(symValid), .symClass(symClass),
    .lineValid(lineValid), .lineCode(lineCode)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int toInt(input logic [1:0] c);
    return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
  endfunction

  task automatic doReset();
    @(negedge clk); rstN = 1'b0; symValid = 1'b0;
    repeat (3) @(negedge clk);
    check(!lineValid && lineCode == 2'b00, "R1", {lineValid, lineCode}, 0);
    rstN = 1'b1;
    @(posedge clk); #1;
    check(!lineValid && lineCode == 2'b00, "R1", {lineValid, lineCode}, 0);
    expLastNeg = 1'b1;
  endtask

  // Drive one cycle and check against the requirement model.
  task automatic step(input logic v, input logic [1:0] c, input string req);
    logic [1:0] exp;
    @(negedge clk);
    symValid = v; symClass = c;
    @(posedge clk); #1;
    exp = 2'b00;
    if (v) begin
      case (c)
        2'b01, 2'b10: begin exp = expLastNeg ? 2'b01 : 2'b11; expLastNeg = ~expLastNeg; end
        2'b11:        exp = expLastNeg ? 2'b11 : 2'b01;
        default:      exp = 2'b00;
      endcase
    end
    check(lineValid == v, "R2", lineValid, v);
    check(lineCode == exp, req, toInt(lineCode), toInt(exp));
  endtask

  logic [1:0] clsArr [NBITS];

  initial begin
    doReset();
    // R5: violation before any pulse is -1, then the first mark is still +1 (R4)
    step(1, 2'b11, "R5");
    step(1, 2'b01, "R4");
    step(1, 2'b11, "R5");
    step(1, 2'b10, "R4");
    step(1, 2'b01, "R4");
    // R3 spaces, R7 idle cycles between pulses
    step(1, 2'b00, "R3");
    step(0, 2'b01, "R7");
    step(0, 2'b11, "R7");
    step(1, 2'b01, "R7");
    step(1, 2'b11, "R5");

    // Near-exhaustive sweep of all 3-cycle (valid, class) sequences
    doReset();
    for (int s = 0; s < 512; s++) begin
      for (int k = 0; k < 3; k++) begin
        int sym;
        sym = (s >> (3 * k)) & 7;
        step(sym[2], sym[1:0], sym[2] ? ((sym[1:0] == 2'b11) ? "R5" :
                                         (sym[1:0] == 2'b00) ? "R3" : "R4") : "R7");
      end
    end

    // Random data substituted into a well-formed class stream
    begin
      int zeros; logic oddPulses;
      zeros = 0; oddPulses = 1'b0;
      for (int i = 0; i < NBITS; i++) begin
        if (($urandom % 3) == 0) begin
          clsArr[i] = 2'b01; oddPulses = ~oddPulses; zeros = 0;
        end else begin
          clsArr[i] = 2'b00; zeros++;
          if (zeros == 4) begin
            if (!oddPulses) clsArr[i-3] = 2'b10;
            clsArr[i] = 2'b11; oddPulses = 1'b0; zeros = 0;
          end
        end
      end
    end
    doReset();
    begin
      int runSum; int lastV; logic haveV;
      runSum = 0; lastV = 0; haveV = 1'b0;
      for (int i = 0; i < NBITS; i++) begin
        step(1, clsArr[i], (clsArr[i] == 2'b11) ? "R5" : "R4");
        runSum += toInt(lineCode);
        check(runSum >= -2 && runSum <= 2, "R9", runSum, 0);
        check(lineCode != 2'b10, "R8", lineCode, 0);
        if (clsArr[i] == 2'b11) begin
          if (haveV) check(toInt(lineCode) == -lastV, "R6", toInt(lineCode), -lastV);
          lastV = toInt(lineCode); haveV = 1'b1;
        end
      end
    end

    @(negedge clk); symValid = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule